// File: doc/BRIEF.md
# Strobed Byte-Port Configuration Slave with Audio Routing Table

This block is the receiving end of a narrow configuration port. A host drives an 8-bit byte through an I/O register. The top bit is a strobe. The lower seven bits carry a code. The slave passes the byte through a two-flop synchroniser and captures the code on each rising edge of the strobe. A code that sets its top bit (0x40 to 0x7F) selects one of 64 internal 6-bit registers. A code below 0x40 is a 6-bit value written into the register selected last.

Registers 0 to 3 hold a destination index (registers 0 and 1, upper and lower six bits) and a source index (registers 2 and 3, upper and lower six bits). A write to register 3 commits the pair into a routing table. In that table every destination holds exactly one source, and one source may serve any number of destinations. Logic next to the block looks up a destination through a read port. The host reads the selected register back in bits [14:8] of a 16-bit word.

Top module: `cfgport_slave`

## Requirements
- R1: After reset the read word is 0x0000, no register is selected, all 64 registers hold 0 and every routing table entry reads 0.
- R2: A code is captured only when port bit 7 goes from 0 to 1 after synchronisation. A code that changes while bit 7 stays high, or while it stays low, has no effect.
- R3: A captured code in 0x40..0x7F selects register (code - 0x40). The read word then shows that register's 6-bit value in bits [13:8], with bit 14, bit 15 and bits [7:0] at 0.
- R4: A captured code in 0x00..0x3F is stored as the new 6-bit value of the selected register. Other registers keep their values.
- R5: Data codes captured before any register has been selected since reset change no register.
- R6: A data write to register 3 sets table[{reg0,reg1}] to the 12-bit source {reg2, new value}, with reg2 in bits [11:6].
- R7: A commit whose 12-bit destination index is not below TBL_DEPTH leaves every table entry unchanged. The index is not truncated onto a valid entry. The register write itself still takes effect.
- R8: A destination holds exactly one source. A new commit to the same destination replaces the old source, and one source may be committed to several destinations at once.
- R9: Writes to registers 0, 1 and 2 alone do not change the routing table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst | input | 1 | Synchronous active-high reset |
| port_in | input | 8 | Host byte: bit 7 strobe, bits [6:0] code |
| rd_word | output | 16 | Host read word: selected register in bits [14:8], zero elsewhere |
| route_rd_dst | input | $clog2(TBL_DEPTH) | Destination looked up in the routing table |
| route_rd_src | output | 12 | Source mapped to route_rd_dst |

## Verification
The bench builds the block with TBL_DEPTH = 8, so the table is small enough to read in full. With that depth, destination indices 8 and 0x040 are out of range, and both would alias onto entry 0 if the index were truncated; the bench commits to them and checks that entry 0 stays clean. The bench also holds the strobe high while the code changes, reuses one source for two destinations, and commits half-written pairs.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int CODE_W  = 7;
    localparam int VAL_W   = 6;
    localparam int REG_CNT = 1 << VAL_W;
    localparam int SEL_W   = VAL_W;
    localparam int ROUTE_W = 2 * VAL_W;

    localparam logic [SEL_W-1:0] REG_DST_HI = 'd0;
    localparam logic [SEL_W-1:0] REG_DST_LO = 'd1;
    localparam logic [SEL_W-1:0] REG_SRC_HI = 'd2;
    localparam logic [SEL_W-1:0] REG_SRC_LO = 'd3;

    typedef enum logic {
        CODE_DATA = 1'b0,
        CODE_SEL  = 1'b1
    } code_kind_e;

    typedef struct packed {
        logic               strobe;
        logic [CODE_W-1:0]  code;
    } port_byte_t;

    typedef struct packed {
        logic               we;
        logic [ROUTE_W-1:0] dst;
        logic [ROUTE_W-1:0] src;
    } route_wr_t;

    function automatic code_kind_e code_kind(input logic [CODE_W-1:0] code);
        return code[CODE_W-1] ? CODE_SEL : CODE_DATA;
    endfunction

    function automatic logic [VAL_W-1:0] code_payload(input logic [CODE_W-1:0] code);
        return code[VAL_W-1:0];
    endfunction

endpackage

// File: rtl/cfgp_port_sync.sv
module cfgp_port_sync
    import cfgp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        port_in,
    output logic              cap_fire,
    output logic [CODE_W-1:0] cap_code
);

    port_byte_t sync_q [SYNC_STAGES];
    logic       strobe_prev_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= '0;
        else     sync_q[0] <= port_byte_t'(port_in);
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) sync_q[s] <= '0;
            else     sync_q[s] <= sync_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) strobe_prev_q <= 1'b0;
        else     strobe_prev_q <= sync_q[SYNC_STAGES-1].strobe;
    end

    assign cap_fire = sync_q[SYNC_STAGES-1].strobe & ~strobe_prev_q;
    assign cap_code = sync_q[SYNC_STAGES-1].code;

endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_fire,
    input  logic [CODE_W-1:0] cap_code,
    output logic              sel_valid,
    output logic [SEL_W-1:0]  sel_idx,
    output logic [VAL_W-1:0]  sel_val,
    output route_wr_t         route_wr
);

    logic [VAL_W-1:0] regs_q [REG_CNT];
    logic             sel_valid_q;
    logic [SEL_W-1:0] sel_idx_q;
    logic             do_select;
    logic             do_write;
    logic [VAL_W-1:0] payload;

    assign payload   = code_payload(cap_code);
    assign do_select = cap_fire && (code_kind(cap_code) == CODE_SEL);
    assign do_write  = cap_fire && (code_kind(cap_code) == CODE_DATA) && sel_valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_valid_q <= 1'b0;
            sel_idx_q   <= '0;
        end else if (do_select) begin
            sel_valid_q <= 1'b1;
            sel_idx_q   <= payload;
        end
    end

    for (genvar r = 0; r < REG_CNT; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                         regs_q[r] <= '0;
            else if (do_write && sel_idx_q == SEL_W'(r))     regs_q[r] <= payload;
        end
    end

    always_comb begin
        route_wr.we  = do_write && (sel_idx_q == REG_SRC_LO);
        route_wr.dst = {regs_q[REG_DST_HI], regs_q[REG_DST_LO]};
        route_wr.src = {regs_q[REG_SRC_HI], payload};
    end

    assign sel_valid = sel_valid_q;
    assign sel_idx   = sel_idx_q;
    assign sel_val   = regs_q[sel_idx_q];

endmodule

// File: rtl/cfgp_route_table.sv
module cfgp_route_table
    import cfgp_pkg::*;
#(
    parameter int TBL_DEPTH = 16,
    localparam int AW = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  route_wr_t          route_wr,
    input  logic [AW-1:0]      rd_dst,
    output logic [ROUTE_W-1:0] rd_src
);

    logic [ROUTE_W-1:0] tbl_q [TBL_DEPTH];
    logic               in_range;

    assign in_range = int'(route_wr.dst) < TBL_DEPTH;

    for (genvar e = 0; e < TBL_DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                tbl_q[e] <= '0;
            else if (route_wr.we && in_range && int'(route_wr.dst) == e)
                tbl_q[e] <= route_wr.src;
        end
    end

    always_comb begin
        rd_src = '0;
        if (int'(rd_dst) < TBL_DEPTH) rd_src = tbl_q[rd_dst];
    end

endmodule

// File: rtl/cfgport_slave.sv
module cfgport_slave
    import cfgp_pkg::*;
#(
    parameter int TBL_DEPTH = 16,
    localparam int AW = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         port_in,
    output logic [15:0]        rd_word,
    input  logic [AW-1:0]      route_rd_dst,
    output logic [ROUTE_W-1:0] route_rd_src
);

    logic              cap_fire;
    logic [CODE_W-1:0] cap_code;
    logic              sel_valid;
    logic [SEL_W-1:0]  sel_idx;
    logic [VAL_W-1:0]  sel_val;
    route_wr_t         route_wr;

    cfgp_port_sync #(.SYNC_STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .port_in  (port_in),
        .cap_fire (cap_fire),
        .cap_code (cap_code)
    );

    cfgp_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .cap_fire  (cap_fire),
        .cap_code  (cap_code),
        .sel_valid (sel_valid),
        .sel_idx   (sel_idx),
        .sel_val   (sel_val),
        .route_wr  (route_wr)
    );

    cfgp_route_table #(.TBL_DEPTH(TBL_DEPTH)) u_table (
        .clk      (clk),
        .rst      (rst),
        .route_wr (route_wr),
        .rd_dst   (route_rd_dst),
        .rd_src   (route_rd_src)
    );

    always_comb begin
        rd_word = '0;
        if (sel_valid) rd_word[14:8] = {1'b0, sel_val};
    end

endmodule

// File: rtl/cfgport_slave_chk.sv
module cfgport_slave_chk
    import cfgp_pkg::*;
#(
    parameter int TBL_DEPTH = 16,
    parameter int AW = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               cap_fire,
    input logic [CODE_W-1:0]  cap_code,
    input logic               sel_valid,
    input logic [SEL_W-1:0]   sel_idx,
    input logic [15:0]        rd_word,
    input route_wr_t          tbl_wr,
    input logic [AW-1:0]      route_rd_dst,
    input logic [ROUTE_W-1:0] route_rd_src
);

    // R2
    no_edge_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_fire |=> $stable(sel_idx) && $stable(sel_valid) && $stable(rd_word));

    // R3
    select_chk: assert property (@(posedge clk) disable iff (rst)
        cap_fire && cap_code[CODE_W-1] |=> sel_valid && sel_idx == $past(cap_code[SEL_W-1:0]));

    // R3
    rd_frame_chk: assert property (@(posedge clk) disable iff (rst)
        rd_word[15:14] == 2'b00 && rd_word[7:0] == 8'h00);

    // R4
    write_chk: assert property (@(posedge clk) disable iff (rst)
        cap_fire && !cap_code[CODE_W-1] && sel_valid |=> rd_word[13:8] == $past(cap_code[VAL_W-1:0]));

    // R5
    no_sel_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_valid |-> rd_word == 16'h0000 && !tbl_wr.we);

    // R6
    commit_chk: assert property (@(posedge clk) disable iff (rst)
        tbl_wr.we && int'(tbl_wr.dst) < TBL_DEPTH && int'(route_rd_dst) == int'(tbl_wr.dst)
        |=> !$stable(route_rd_dst) || route_rd_src == $past(tbl_wr.src));

    // R9
    table_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !tbl_wr.we |=> !$stable(route_rd_dst) || $stable(route_rd_src));

endmodule

bind cfgport_slave cfgport_slave_chk #(.TBL_DEPTH(TBL_DEPTH), .AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cap_fire     (cap_fire),
    .cap_code     (cap_code),
    .sel_valid    (sel_valid),
    .sel_idx      (sel_idx),
    .rd_word      (rd_word),
    .tbl_wr       (route_wr),
    .route_rd_dst (route_rd_dst),
    .route_rd_src (route_rd_src)
);

// File: tb/cfgport_slave_bench.sv
module cfgport_slave_bench;

    localparam int DEPTH = 8;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    port_in = 8'h00;
    logic [15:0]   rd_word;
    logic [AW-1:0] route_rd_dst = '0;
    logic [11:0]   route_rd_src;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cfgport_slave #(.TBL_DEPTH(DEPTH)) u_cfgport_slave (
        .clk          (clk),
        .rst          (rst),
        .port_in      (port_in),
        .rd_word      (rd_word),
        .route_rd_dst (route_rd_dst),
        .route_rd_src (route_rd_src)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic drive(input logic [7:0] b, input int cyc);
        port_in = b;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic send_code(input logic [6:0] code);
        drive({1'b0, code}, 4);
        drive({1'b1, code}, 4);
        drive({1'b0, code}, 4);
    endtask

    task automatic set_reg(input logic [5:0] idx, input logic [5:0] val);
        send_code({1'b1, idx});
        send_code({1'b0, val});
    endtask

    task automatic map(input logic [11:0] dst, input logic [11:0] src);
        set_reg(6'd0, dst[11:6]);
        set_reg(6'd1, dst[5:0]);
        set_reg(6'd2, src[11:6]);
        set_reg(6'd3, src[5:0]);
    endtask

    task automatic look(input int dst, output int src);
        route_rd_dst = AW'(dst);
        #1;
        src = int'(route_rd_src);
    endtask

    task automatic t_reset();
        int s;
        chk("R1 rd_word after reset", rd_word, 16'h0000);
        for (int i = 0; i < DEPTH; i++) begin
            look(i, s);
            chk("R1 table entry after reset", s, 0);
        end
    endtask

    task automatic t_pre_select();
        send_code(7'h15);
        chk("R5 data before select, rd_word", rd_word, 16'h0000);
        send_code(7'h45);
        chk("R5 register 5 untouched by early data", rd_word, 16'h0000);
    endtask

    task automatic t_select_write();
        send_code(7'h2A);
        chk("R4 write 0x2A to reg 5", rd_word, 16'h2A00);
        set_reg(6'd9, 6'h3F);
        chk("R3 R4 reg 9 = 0x3F, bit 14 zero", rd_word, 16'h3F00);
        send_code(7'h45);
        chk("R4 reg 5 kept after reg 9 write", rd_word, 16'h2A00);
    endtask

    task automatic t_strobe_level();
        drive(8'h45, 4);
        drive(8'hC5, 4);
        drive(8'h91, 8);
        drive(8'h11, 4);
        chk("R2 code change while strobe high ignored", rd_word, 16'h2A00);
        drive(8'h22, 8);
        chk("R2 code change while strobe low ignored", rd_word, 16'h2A00);
    endtask

    task automatic t_route();
        int s;
        map(12'd3, 12'h123);
        map(12'd5, 12'h123);
        look(3, s); chk("R6 R8 dst 3 -> 0x123", s, 12'h123);
        look(5, s); chk("R8 dst 5 shares source 0x123", s, 12'h123);
        map(12'd3, 12'hFC0);
        look(3, s); chk("R8 dst 3 replaced by 0xFC0", s, 12'hFC0);
        look(5, s); chk("R8 dst 5 unchanged", s, 12'h123);
    endtask

    task automatic t_partial();
        int s;
        set_reg(6'd0, 6'd0);
        set_reg(6'd1, 6'd6);
        set_reg(6'd2, 6'd1);
        look(6, s); chk("R9 no commit before reg 3", s, 0);
        set_reg(6'd3, 6'd2);
        look(6, s); chk("R6 commit on reg 3 write, src 0x042", s, 12'h042);
    endtask

    task automatic t_range();
        int s;
        map(12'd8, 12'h7FF);
        look(0, s); chk("R7 dst 8 does not alias entry 0", s, 0);
        map(12'h040, 12'h555);
        look(0, s); chk("R7 dst 0x040 does not alias entry 0", s, 0);
        chk("R7 reg 3 still written", rd_word, 16'h1500);
        look(6, s); chk("R7 entry 6 unchanged", s, 12'h042);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pre_select();
        t_select_write();
        t_strobe_level();
        t_route();
        t_partial();
        t_range();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule